// File: doc/BRIEF.md
# Accumulator Fetch-Execute Processor

A minimal processor that reads byte-wide instructions from an external, byte-addressed memory and executes them. It drives a 16-bit address, a read strobe and an 8-bit read-data input. The memory returns data one cycle after the strobe. The core holds a 16-bit program counter, four 8-bit general registers (A, B, C and D) and a carry flag. Only A is the target of the instruction set.

The instruction set has three operations. `B0h imm` loads `imm` into A. `04h imm` adds `imm` to A. `F4h` halts the core. Every other opcode is a one-byte no-operation. A controller with enumerated states runs each instruction. FETCH drives the program counter with the read strobe. DECODE captures the opcode. OPERAND reads the immediate byte. EXECUTE writes A. HALT is a terminal state that only reset leaves.

The state transitions are:
- FETCH→DECODE, always.
- DECODE→OPERAND when the opcode takes an immediate byte.
- DECODE→HALT on `F4h`.
- DECODE→FETCH on any other opcode.
- OPERAND→EXECUTE, always.
- EXECUTE→FETCH, always.
- HALT→HALT, until reset.

Register A, the carry flag, the program counter and a halted flag are brought out so that the surrounding logic can observe progress.

Top module: `acc_core`

## Requirements
- R1: While reset is held and after it is released, the program counter reads 1400h, register A reads 00h, carry reads 0 and halted reads 0.
- R2: Each memory read asserts `mem_rd` for one cycle with the byte address on `mem_addr`. The core consumes `mem_rdata` in the following cycle.
- R3: Opcode B0h loads the next byte into A and clears carry.
- R4: Opcode 04h adds the next byte to A modulo 256 and sets carry to the carry-out of that addition.
- R5: Bytes are read in strictly ascending address order. After a two-byte instruction at address X, the next opcode read is at X+2.
- R6: On opcode F4h the halted flag goes to 1 and the program counter stays at the address of the F4h byte. `mem_rd` is never asserted again.
- R7: Any opcode other than B0h, 04h and F4h is a one-byte no-operation. It leaves A and carry unchanged, and the next opcode is read at X+1.
- R8: Once halted, the core stays halted until reset. After a reset it restarts at 1400h.
- R9: A two-byte instruction occupies four cycles. The new value of A is visible two cycles after the cycle that reads its immediate byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Byte address of the memory read (the program counter) |
| mem_rd | output | 1 | Read strobe; data returns on the next cycle |
| mem_rdata | input | 8 | Byte returned by memory |
| acc_a | output | 8 | Contents of register A |
| carry | output | 1 | Carry flag from the last add |
| halted | output | 1 | High once the halt opcode has been executed |
| pc | output | 16 | Current program counter |

## Verification
A controller in the wrong state shows up directly on the read strobe. An extra or missing read, or a read at the wrong address, appears in the very cycle it happens. The bench compares every strobe against the ordered list of addresses that the program implies. A wrong operand path or adder shows in A and carry exactly two cycles after the immediate byte is read. A bad halt shows as strobe activity or program-counter motion after the halted flag rises.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
    localparam logic [7:0] OP_LOAD = 8'hB0;
    localparam logic [7:0] OP_ADD  = 8'h04;
    localparam logic [7:0] OP_HALT = 8'hF4;

    typedef enum logic [2:0] {
        ST_FETCH   = 3'd0,
        ST_DECODE  = 3'd1,
        ST_OPERAND = 3'd2,
        ST_EXECUTE = 3'd3,
        ST_HALT    = 3'd4
    } core_state_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    output logic [DW-1:0] sum,
    output logic          cout
);
    assign {cout, sum} = {1'b0, lhs} + {1'b0, rhs};
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int DW    = 8,
    parameter int NREGS = 4,
    localparam int SW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [SW-1:0] rd_sel,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] regs [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en && wr_sel == SW'(i))
                regs[i] <= wr_data;
        end
    end

    assign rd_data = regs[rd_sel];
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_core_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter logic [AW-1:0] START_PC = 16'h1400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic          mem_rd,
    output logic          do_load,
    output logic          do_add,
    output logic          halted
);
    core_state_e   state, state_nxt;
    logic [DW-1:0] opcode;
    logic          two_byte;

    assign two_byte = (mem_rdata == OP_LOAD) || (mem_rdata == OP_ADD);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FETCH:   state_nxt = ST_DECODE;
            ST_DECODE: begin
                if (mem_rdata == OP_HALT) state_nxt = ST_HALT;
                else if (two_byte)        state_nxt = ST_OPERAND;
                else                      state_nxt = ST_FETCH;
            end
            ST_OPERAND: state_nxt = ST_EXECUTE;
            ST_EXECUTE: state_nxt = ST_FETCH;
            ST_HALT:    state_nxt = ST_HALT;
            default:    state_nxt = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_FETCH;
            pc     <= START_PC;
            opcode <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_DECODE)
                opcode <= mem_rdata;
            if ((state == ST_DECODE && mem_rdata != OP_HALT) || state == ST_EXECUTE)
                pc <= pc + AW'(1);
        end
    end

    always_comb begin
        mem_rd  = 1'b0;
        do_load = 1'b0;
        do_add  = 1'b0;
        halted  = 1'b0;
        unique case (state)
            ST_FETCH, ST_OPERAND: mem_rd = 1'b1;
            ST_EXECUTE: begin
                do_load = (opcode == OP_LOAD);
                do_add  = (opcode == OP_ADD);
            end
            ST_HALT:  halted = 1'b1;
            default:  ;
        endcase
    end

    // R6
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_rd);
    // R6
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && mem_rdata == OP_HALT) |=> (halted && $stable(pc)));
    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    // R9
    exec_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_load || do_add) |=> mem_rd);
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 8,
    parameter int            NREGS    = 4,
    parameter logic [AW-1:0] START_PC = 16'h1400,
    localparam int           SW       = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] acc_a,
    output logic          carry,
    output logic          halted,
    output logic [AW-1:0] pc
);
    localparam logic [SW-1:0] SEL_A = '0;

    logic          do_load, do_add;
    logic [DW-1:0] sum;
    logic          cout;
    logic [DW-1:0] wr_data;

    acc_ctrl #(.AW(AW), .DW(DW), .START_PC(START_PC)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .pc(pc),
        .mem_rd(mem_rd), .do_load(do_load), .do_add(do_add), .halted(halted)
    );

    acc_alu #(.DW(DW)) alu_i (
        .lhs(acc_a), .rhs(mem_rdata), .sum(sum), .cout(cout)
    );

    assign wr_data = do_load ? mem_rdata : sum;

    acc_regfile #(.DW(DW), .NREGS(NREGS)) rf_i (
        .clk(clk), .rst_n(rst_n), .wr_en(do_load || do_add), .wr_sel(SEL_A),
        .wr_data(wr_data), .rd_sel(SEL_A), .rd_data(acc_a)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       carry <= 1'b0;
        else if (do_load) carry <= 1'b0;
        else if (do_add)  carry <= cout;
    end

    assign mem_addr = pc;

    // R3
    load_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (!carry && acc_a == $past(mem_rdata)));
    // R4
    add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_add |=> ({carry, acc_a} == ({1'b0, $past(acc_a)} + {1'b0, $past(mem_rdata)})));
endmodule

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  acc_a;
    logic        carry, halted;
    logic [15:0] pc;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct { logic [15:0] addr; logic [7:0] a; logic c; } res_t;
    logic [15:0] exp_rd [$];
    res_t        exp_res [$];
    logic [7:0]  mem [0:255];

    always #2 clk = ~clk;

    acc_core dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .acc_a(acc_a), .carry(carry),
        .halted(halted), .pc(pc)
    );

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // monitor: scoreboard of reads and register results
    int   pend = 0;
    res_t pend_item;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    check("R9/R3/R4 A", 32'(acc_a), 32'(pend_item.a));
                    check("R9/R3/R4 carry", 32'(carry), 32'(pend_item.c));
                end
            end
            if (mem_rd) begin
                if (exp_rd.size() == 0) begin
                    check("R6 unexpected read", 32'(mem_addr), 32'hFFFF_FFFF);
                end else begin
                    check("R2/R5 read addr", 32'(mem_addr), 32'(exp_rd.pop_front()));
                end
                if (exp_res.size() != 0 && exp_res[0].addr == mem_addr) begin
                    pend_item = exp_res.pop_front();
                    pend = 2;
                end
            end
        end
    end

    // driver: interprets memory image and pushes expectations, then runs core
    task automatic run_prog(input logic [15:0] halt_pc_exp, input logic [7:0] a_exp);
        logic [7:0]  a = 8'h00;
        logic        c = 1'b0;
        logic [15:0] ad = 16'h1400;
        logic [8:0]  s;
        int          guard = 0;
        forever begin
            logic [7:0] op;
            op = mem[ad[7:0]];
            exp_rd.push_back(ad);
            if (op == 8'hF4) break;
            if (op == 8'hB0 || op == 8'h04) begin
                exp_rd.push_back(ad + 16'd1);
                if (op == 8'hB0) begin a = mem[ad[7:0] + 8'd1]; c = 1'b0; end
                else begin s = {1'b0, a} + {1'b0, mem[ad[7:0] + 8'd1]}; a = s[7:0]; c = s[8]; end
                exp_res.push_back('{addr: ad + 16'd1, a: a, c: c});
                ad = ad + 16'd2;
            end else begin
                ad = ad + 16'd1;
            end
        end
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 pc in reset", 32'(pc), 32'h1400);
        check("R1 A in reset", 32'(acc_a), 32'h0);
        check("R1 carry/halted in reset", 32'({carry, halted}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 halted cleared after reset", 32'(halted), 32'h0);
        while (!halted && guard < 500) begin @(negedge clk); guard++; end
        check("R6 halted", 32'(halted), 32'h1);
        check("R6 pc at halt", 32'(pc), 32'(halt_pc_exp));
        check("R3/R4 final A", 32'(acc_a), 32'(a_exp));
        check("R3/R4 final A vs model", 32'(acc_a), 32'(a));
        repeat (20) @(negedge clk);
        check("R6 no read after halt", 32'(mem_rd), 32'h0);
        check("R6 pc frozen", 32'(pc), 32'(halt_pc_exp));
        check("R8 still halted", 32'(halted), 32'h1);
        check("R5 all reads seen", 32'(exp_rd.size()), 32'h0);
        check("R9 all results seen", 32'(exp_res.size()), 32'h0);
        exp_rd.delete();
        exp_res.delete();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hF4;
        // program 1: load 21, add 42, add 12, halt
        mem[0] = 8'hB0; mem[1] = 8'h21; mem[2] = 8'h04; mem[3] = 8'h42;
        mem[4] = 8'h04; mem[5] = 8'h12; mem[6] = 8'hF4;
        run_prog(16'h1406, 8'h75);
        // program 2: carry set, nop (R7), load clears carry, wrap to zero
        mem[0] = 8'hB0; mem[1] = 8'hF0; mem[2] = 8'h04; mem[3] = 8'h20;
        mem[4] = 8'h01; mem[5] = 8'hB0; mem[6] = 8'h05; mem[7] = 8'h04;
        mem[8] = 8'hFB; mem[9] = 8'h37; mem[10] = 8'hF4;
        run_prog(16'h140A, 8'h00);
        check("R4 carry from wrap", 32'(carry), 32'h1);
        // program 3: immediate halt, R7 nop only program
        mem[0] = 8'h00; mem[1] = 8'hF4;
        run_prog(16'h1401, 8'h00);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule